// File: doc/BRIEF.md
# SIMT Execution Mask Controller

This block keeps the per-lane active mask of a 64-lane vector unit and rewrites it as a sequencer steps through structured divergent code. Each accepted command (one per cycle, qualified by a valid bit) carries an opcode, a 64-bit per-lane condition vector and a small loop-level index. Two-way branches narrow the mask to the lanes that passed a compare and park the remaining lanes on an internal stack of saved masks. The else-part swaps the lane sets, and the join merges the lanes back. Loops collect exiting lanes in a per-level break mask and strip them out at the back-edge.

The registered mask drives the lane enables of the vector datapath. An all-clear flag lets the sequencer jump over a region in which no lane would execute. A loop-taken flag tells it whether to branch back to the loop head. Misuse of the stack (pushing past its depth, or reading it while empty) raises a sticky fault and leaves the mask alone.

Top module: `exm_ctrl`

## Requirements
- R1: After a synchronous active-low reset the mask is all ones, the all-clear flag, the loop-taken flag and the fault flag are 0, the saved-mask stack is empty and every break mask is zero.
- R2: Every result (mask, all-clear flag, loop-taken flag, fault) appears on the outputs in the cycle after the command is accepted. When `cmd_valid` is low, all outputs hold.
- R3: Opcode 1 (branch) with a non-full stack sets the mask to old mask AND condition, and pushes old mask AND NOT condition (the failing lanes).
- R4: Opcode 2 (else) with a non-empty stack sets the mask to (mask OR top) XOR mask, and replaces the stack top with the mask held before the command.
- R5: Opcode 3 (join) with a non-empty stack sets the mask to mask OR top, and pops the stack.
- R6: Opcode 4 (break) ORs the current mask into the break mask selected by `cmd_idx`, and leaves the mask unchanged.
- R7: Opcode 5 (loop) computes mask AND NOT break[`cmd_idx`]. If that is non-zero, it becomes the mask and loop-taken goes to 1. Otherwise the mask is loaded from break[`cmd_idx`], that break mask is cleared, and loop-taken is 0.
- R8: Opcode 0 (set) loads the mask directly from `cmd_cond`.
- R9: `exec_zero` is 1 exactly when the registered mask is all zeros.
- R10: A branch with 8 entries already stacked, or an else or join with the stack empty, sets the sticky fault. The mask and the stack are left unchanged, and the fault is cleared only by reset.
- R11: Opcodes 6 and 7 are ignored: no output or internal state changes.
- R12: Loop-taken is cleared by every accepted opcode 0 to 4, and by a loop command that exits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Opcode: 0 set, 1 branch, 2 else, 3 join, 4 break, 5 loop |
| cmd_cond | input | 64 | Per-lane condition or direct mask value |
| cmd_idx | input | 2 | Loop level selecting a break mask |
| exec_mask | output | 64 | Current lane enable mask |
| exec_zero | output | 1 | Mask is all clear |
| loop_taken | output | 1 | Loop back-edge should be taken |
| fault | output | 1 | Sticky stack misuse flag |

## Verification
The assertions check on every cycle that the all-clear flag agrees with the mask, that the fault stays set once raised, and that a raised loop-taken flag never comes with an empty mask. They also check the one-cycle results of set, branch and join, and that a faulting push leaves the mask stable. The bench scenarios are needed to show the stack contents across nested branches, the else swap, break masks that build up over several iterations, the restore of the mask when a loop exits, and the ignored opcodes. Only there are the results compared against a bench model over long random command streams.

// File: rtl/exm_pkg.sv
// Package: shared opcode encoding for the execution mask controller.
// Assumes a 3-bit opcode field; codes 6 and 7 are reserved and ignored.
package exm_pkg;
    typedef enum logic [2:0] {
        OP_SET   = 3'd0,
        OP_IF    = 3'd1,
        OP_ELSE  = 3'd2,
        OP_JOIN  = 3'd3,
        OP_BREAK = 3'd4,
        OP_LOOP  = 3'd5
    } exm_op_e;
endpackage

// File: rtl/exm_mask_stack.sv
// Module: LIFO of saved lane masks with push, pop and replace-top.
// Assumes the caller never asserts push on full, or pop/repl on empty;
// the controller screens those cases and raises its fault instead.
module exm_mask_stack #(
    parameter int W     = 64,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic         repl,
    input  logic [W-1:0] din,
    output logic [W-1:0] top,
    output logic         full,
    output logic         empty
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] cnt;
    logic [AW-1:0] top_ptr;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign top_ptr = AW'(cnt - CW'(1));
    assign top     = empty ? '0 : mem[top_ptr];

    // Occupancy counter: one entry up on push, one down on pop.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (push)   cnt <= cnt + CW'(1);
        else if (pop)    cnt <= cnt - CW'(1);
    end

    // Entry storage: write the next free slot on push, or the top on replace.
    always_ff @(posedge clk) begin
        if (push)        mem[AW'(cnt)] <= din;
        else if (repl)   mem[top_ptr]  <= din;
    end
endmodule

// File: rtl/exm_brk_bank.sv
// Module: one accumulating break mask for each loop nesting level.
// Assumes a single write port; the read is combinational from the index.
module exm_brk_bank #(
    parameter int W      = 64,
    parameter int LEVELS = 4,
    localparam int IW    = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  rd
);
    logic [W-1:0] bank [LEVELS];

    assign rd = bank[idx];

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        // Level register: cleared by reset, loaded when selected and written.
        always_ff @(posedge clk) begin
            if (!rst_n)                        bank[g] <= '0;
            else if (we && idx == IW'(g))      bank[g] <= din;
        end
    end
endmodule

// File: rtl/exm_ctrl.sv
// Module: execution mask controller for structured divergent control flow.
// Decodes one command per cycle, computes the next lane mask, and drives
// the saved-mask stack and the break-mask bank. Every result is registered,
// so the outputs follow the accepted command by one cycle.
module exm_ctrl #(
    parameter int LANES  = 64,
    parameter int DEPTH  = 8,
    parameter int LEVELS = 4,
    localparam int IW    = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [LANES-1:0] cmd_cond,
    input  logic [IW-1:0]    cmd_idx,
    output logic [LANES-1:0] exec_mask,
    output logic             exec_zero,
    output logic             loop_taken,
    output logic             fault
);
    import exm_pkg::*;

    logic [LANES-1:0] exec_q, nxt_exec, stk_din, stk_top, brk_rd, brk_din, loop_rem;
    logic             zero_q, loop_q, fault_q, nxt_loop, set_fault;
    logic             push, pop, repl, stk_full, stk_empty, brk_we;

    exm_mask_stack #(.W(LANES), .DEPTH(DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .repl(repl),
        .din(stk_din), .top(stk_top), .full(stk_full), .empty(stk_empty)
    );

    exm_brk_bank #(.W(LANES), .LEVELS(LEVELS)) u_brk (
        .clk(clk), .rst_n(rst_n), .we(brk_we), .idx(cmd_idx),
        .din(brk_din), .rd(brk_rd)
    );

    assign loop_rem = exec_q & ~brk_rd;

    // Command decode: next mask, stack and break-bank controls, fault request.
    always_comb begin
        nxt_exec  = exec_q;
        nxt_loop  = loop_q;
        push      = 1'b0;
        pop       = 1'b0;
        repl      = 1'b0;
        stk_din   = exec_q;
        brk_we    = 1'b0;
        brk_din   = brk_rd;
        set_fault = 1'b0;
        if (cmd_valid) begin
            case (cmd_op)
                OP_SET: begin
                    nxt_exec = cmd_cond;
                    nxt_loop = 1'b0;
                end
                OP_IF: begin
                    nxt_loop = 1'b0;
                    if (stk_full) set_fault = 1'b1;
                    else begin
                        push     = 1'b1;
                        nxt_exec = exec_q & cmd_cond;
                        stk_din  = exec_q ^ (exec_q & cmd_cond);
                    end
                end
                OP_ELSE: begin
                    nxt_loop = 1'b0;
                    if (stk_empty) set_fault = 1'b1;
                    else begin
                        repl     = 1'b1;
                        stk_din  = exec_q;
                        nxt_exec = (exec_q | stk_top) ^ exec_q;
                    end
                end
                OP_JOIN: begin
                    nxt_loop = 1'b0;
                    if (stk_empty) set_fault = 1'b1;
                    else begin
                        pop      = 1'b1;
                        nxt_exec = exec_q | stk_top;
                    end
                end
                OP_BREAK: begin
                    nxt_loop = 1'b0;
                    brk_we   = 1'b1;
                    brk_din  = brk_rd | exec_q;
                end
                OP_LOOP: begin
                    if (loop_rem != '0) begin
                        nxt_exec = loop_rem;
                        nxt_loop = 1'b1;
                    end else begin
                        nxt_exec = brk_rd;
                        brk_we   = 1'b1;
                        brk_din  = '0;
                        nxt_loop = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Output registers: mask, all-clear flag, loop flag, sticky fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec_q  <= '1;
            zero_q  <= 1'b0;
            loop_q  <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            exec_q  <= nxt_exec;
            zero_q  <= (nxt_exec == '0);
            loop_q  <= nxt_loop;
            fault_q <= fault_q | set_fault;
        end
    end

    assign exec_mask  = exec_q;
    assign exec_zero  = zero_q;
    assign loop_taken = loop_q;
    assign fault      = fault_q;

    // R9: the all-clear flag tracks the mask register.
    a_r9_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        exec_zero == (exec_mask == '0));

    // R10: the fault is sticky until reset.
    a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);

    // R10: a push onto a full stack leaves the mask untouched.
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_IF && stk_full) |=> ($stable(exec_mask) && fault));

    // R3: a branch narrows the mask to the passing lanes.
    a_r3_branch_and: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_IF && !stk_full)
        |=> exec_mask == ($past(exec_mask) & $past(cmd_cond)));

    // R5: a join only adds lanes.
    a_r5_join_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_JOIN && !stk_empty)
        |=> (exec_mask & $past(exec_mask)) == $past(exec_mask));

    // R8: set loads the operand.
    a_r8_set_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_SET) |=> exec_mask == $past(cmd_cond));

    // R7: the back-edge is never requested with no live lanes.
    a_r7_loop_live: assert property (@(posedge clk) disable iff (!rst_n)
        loop_taken |-> exec_mask != '0);
endmodule

// File: tb/tb_exm_ctrl.sv
module tb_exm_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 64;
    localparam int DEPTH = 8;
    localparam int LEVELS = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [2:0]       cmd_op = '0;
    logic [LANES-1:0] cmd_cond = '0;
    logic [1:0]       cmd_idx = '0;
    logic [LANES-1:0] exec_mask;
    logic             exec_zero, loop_taken, fault;

    int n_chk = 0;
    int n_bad = 0;

    // Bench model state.
    logic [LANES-1:0] m_exec;
    logic [LANES-1:0] m_stk [DEPTH];
    int               m_cnt;
    logic [LANES-1:0] m_brk [LEVELS];
    logic             m_loop, m_fault;

    exm_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_cond(cmd_cond), .cmd_idx(cmd_idx), .exec_mask(exec_mask),
        .exec_zero(exec_zero), .loop_taken(loop_taken), .fault(fault)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired: got hang, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    task automatic chk(input string tag, input logic [LANES-1:0] got, input logic [LANES-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " mask"}, exec_mask, m_exec);
        chk({"R9 ", tag, " zero"}, 64'(exec_zero), 64'(m_exec == '0));
        chk({"R7/R12 ", tag, " loop"}, 64'(loop_taken), 64'(m_loop));
        chk({"R10 ", tag, " fault"}, 64'(fault), 64'(m_fault));
    endtask

    task automatic model_reset();
        m_exec = '1; m_cnt = 0; m_loop = 0; m_fault = 0;
        for (int i = 0; i < LEVELS; i++) m_brk[i] = '0;
    endtask

    // Spec model of one accepted command.
    task automatic model_step(input logic [2:0] op, input logic [LANES-1:0] c, input int ix);
        logic [LANES-1:0] old, rem;
        old = m_exec;
        case (op)
            3'd0: begin m_exec = c; m_loop = 0; end
            3'd1: begin
                m_loop = 0;
                if (m_cnt == DEPTH) m_fault = 1;
                else begin m_stk[m_cnt] = old & ~c; m_cnt++; m_exec = old & c; end
            end
            3'd2: begin
                m_loop = 0;
                if (m_cnt == 0) m_fault = 1;
                else begin m_exec = m_stk[m_cnt-1] & ~old; m_stk[m_cnt-1] = old; end
            end
            3'd3: begin
                m_loop = 0;
                if (m_cnt == 0) m_fault = 1;
                else begin m_cnt--; m_exec = old | m_stk[m_cnt]; end
            end
            3'd4: begin m_loop = 0; m_brk[ix] = m_brk[ix] | old; end
            3'd5: begin
                rem = old & ~m_brk[ix];
                if (rem != '0) begin m_exec = rem; m_loop = 1; end
                else begin m_exec = m_brk[ix]; m_brk[ix] = '0; m_loop = 0; end
            end
            default: ;
        endcase
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cmd_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // Drive at a falling edge, check at the next falling edge.
    task automatic cmd(input logic [2:0] op, input logic [LANES-1:0] c, input int ix, input string tag);
        cmd_valid = 1'b1; cmd_op = op; cmd_cond = c; cmd_idx = 2'(ix);
        model_step(op, c, ix);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk_all(tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();
        chk_all("R1 reset");

        // Nested branch / else / join.
        cmd(3'd1, 64'h0000_FFFF_0000_FFFF, 0, "R3 branch");
        cmd(3'd1, 64'h00FF_00FF_00FF_00FF, 0, "R3 nested branch");
        cmd(3'd2, '0, 0, "R4 else");
        cmd(3'd3, '0, 0, "R5 join inner");
        cmd(3'd2, '0, 0, "R4 outer else");
        cmd(3'd3, '0, 0, "R5 join outer");
        chk("R5 full restore", exec_mask, '1);

        // Idle cycle: outputs hold.
        @(negedge clk);
        chk_all("R2 idle hold");

        // Loop with breaks accumulating over iterations.
        cmd(3'd0, 64'h0000_0000_0000_00FF, 0, "R8 set");
        cmd(3'd1, 64'h0000_0000_0000_0003, 0, "R3 break cond");
        cmd(3'd4, '0, 1, "R6 break lvl1");
        cmd(3'd3, '0, 0, "R5 join");
        cmd(3'd5, '0, 1, "R7 loop taken");
        chk("R7 loop taken flag", 64'(loop_taken), 64'd1);
        cmd(3'd4, '0, 1, "R6 break rest");
        cmd(3'd5, '0, 1, "R7 loop exit");
        chk("R7 exit restores", exec_mask, 64'h0000_0000_0000_00FF);
        cmd(3'd0, 64'h0, 0, "R8 set zero");
        chk("R9 zero flag", 64'(exec_zero), 64'd1);

        // Ignored opcodes.
        cmd(3'd0, 64'h1234_5678_9ABC_DEF0, 0, "R8 set");
        cmd(3'd6, 64'h0, 0, "R11 op6 ignored");
        cmd(3'd7, 64'h0, 2, "R11 op7 ignored");
        chk("R11 mask kept", exec_mask, 64'h1234_5678_9ABC_DEF0);

        // Underflow, then overflow.
        cmd(3'd3, '0, 0, "R10 join on empty");
        chk("R10 fault set", 64'(fault), 64'd1);
        do_reset();
        chk_all("R1 reset again");
        cmd(3'd2, '0, 0, "R10 else on empty");
        do_reset();
        for (int i = 0; i < DEPTH; i++) cmd(3'd1, '1, 0, "R3 fill");
        cmd(3'd1, 64'h0, 0, "R10 push on full");
        chk("R10 mask unchanged", exec_mask, '1);
        cmd(3'd3, '0, 0, "R10 stack intact join");

        // Random streams.
        for (int run = 0; run < 8; run++) begin
            do_reset();
            for (int k = 0; k < 400; k++) begin
                logic [2:0] op;
                logic [LANES-1:0] c;
                op = 3'($urandom_range(0, 7));
                if (op == 3'd1 && m_cnt >= DEPTH - 1 && ($urandom % 4) != 0) op = 3'd3;
                c = {$urandom, $urandom};
                if (($urandom % 3) == 0) c = c | {$urandom, $urandom};
                cmd(op, c, int'($urandom_range(0, LEVELS - 1)), "R2 random");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule